// File: doc/BRIEF.md
# Edge-Triggered Interrupt Flag Controller

This block gathers the interrupt sources of a small peripheral into one active-high request line. Four external control lines are watched for level changes. Each line has its own polarity select, so it can flag a rising or a falling transition. Two timers and a shift engine send one-cycle set strobes. The data-port and counter logic around the block send one-cycle clear strobes when software touches their registers. Every source owns one bit of a seven-bit flag register. A seven-bit enable register masks the flags, and the request line is high while any enabled flag is set.

Software reaches the block through a byte-wide register port. One address holds a small control register: the per-line polarity selects and two "independent" bits for the secondary lines. Another address holds the flag register. Writing ones to it clears flags, and reading it returns the flags plus a computed summary bit. A third address holds the enable register. A write to it either sets or clears the ones it carries, as bit 7 chooses. The timers, the shifter and the port data paths are outside the block and only deliver strobes.

Top module: `irq_flag_ctrl`

## Requirements
- R1: `irq` is 1 exactly when some bit position is 1 in both the flag register and the enable register, and 0 otherwise.
- R2: Control line `ctl_line[i]` sets flag bit 0, 1, 3, 4 for i = 0, 1, 2, 3. A flag bit is set in the clock edge at which the sampled level first differs from the level sampled one cycle earlier. When control bit i is 1, only a 0-to-1 change sets the flag; when it is 0, only a 1-to-0 change does. A line that keeps its level sets nothing.
- R3: `tmr1_hit`, `tmr2_hit` and `shf_done` set flag bits 6, 5 and 2 on every cycle they are high, whatever the flag held before. A flag that was cleared is set again by the next pulse.
- R4: A write to address 1 clears each flag bit 6:0 whose written bit is 1 and leaves the bits written as 0 unchanged.
- R5: A write to address 2 with data bit 7 = 1 ORs data bits 6:0 into the enable register. With data bit 7 = 0, each enable bit whose data bit is 1 is cleared and the others are kept.
- R6: Reading address 2 returns the enable register in bits 6:0 with bit 7 always 1.
- R7: Reading address 1 returns the flags in bits 6:0, and in bit 7 the same value as `irq`.
- R8: After a synchronous reset (`rst_n` low at a clock edge), the flag, enable and control registers all read as zero, apart from the forced bit 7 of the enable read.
- R9: When a set source and a clear source target the same flag bit in the same cycle, the bit ends up set.
- R10: `porta_ack` clears flag bit 1, and also bit 0 unless control bit 4 is 1. `portb_ack` clears flag bit 4, and also bit 3 unless control bit 5 is 1.
- R11: `tmr1_ack`, `tmr2_ack` and `shf_ack` each clear only flag bit 6, 5 and 2 respectively.
- R12: Address 0 is the control register. Bits 3:0 are the polarity selects of lines 0..3, and bits 5:4 are the independent bits of lines 0 and 2. It reads back in bits 5:0, with bits 7:6 reading 0. Address 3 reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_line | input | 4 | Control line levels, already synchronous to `clk` |
| tmr1_hit | input | 1 | Timer 1 expiry strobe (sets bit 6) |
| tmr2_hit | input | 1 | Timer 2 expiry strobe (sets bit 5) |
| shf_done | input | 1 | Shift-engine completion strobe (sets bit 2) |
| tmr1_ack | input | 1 | Clear strobe for bit 6 |
| tmr2_ack | input | 1 | Clear strobe for bit 5 |
| shf_ack | input | 1 | Clear strobe for bit 2 (shift data read) |
| porta_ack | input | 1 | Port A data access clear strobe |
| portb_ack | input | 1 | Port B data access clear strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 flags, 2 enables) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request, active high |

## Verification
The edge properties assume that the control lines are low while reset is held. The previous-level registers reset to 0, so a line held high through reset would look like a rising edge on the first cycle. The bench keeps all four lines low before and during every reset. The clear-after-write property assumes that no set strobe and no line change happens in the same cycle, because R9 lets a set win. The bench drives every input at the falling clock edge and only overlaps sets with clears in the cases written for R9.

// File: rtl/irq_pkg.sv
// Package: shared widths, flag bit positions and register addresses
// for the interrupt flag controller.
package irq_pkg;
    localparam int DATA_W  = 8;
    localparam int FLAG_W  = 7;
    localparam int LINE_N  = 4;
    localparam int CTRL_W  = LINE_N + 2;

    // Flag bit positions (software decodes these).
    localparam int FB_A_SEC = 0;
    localparam int FB_A_PRI = 1;
    localparam int FB_SHF   = 2;
    localparam int FB_B_SEC = 3;
    localparam int FB_B_PRI = 4;
    localparam int FB_TMR2  = 5;
    localparam int FB_TMR1  = 6;

    // Control register: bits LINE_N-1:0 polarity, then independent bits.
    localparam int CB_A_IND = LINE_N;
    localparam int CB_B_IND = LINE_N + 1;

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_FLAG = 2'd1,
        RA_ENAB = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;

    // Maps control line index to its flag bit.
    function automatic int line_to_flag(input int idx);
        return (idx < 2) ? idx : idx + 1;
    endfunction
endpackage

// File: rtl/irq_edge_det.sv
// Module: single-line edge detector with polarity select.
// Assumes lvl is already synchronous to clk and low during reset.
// hit is combinational: high in the cycle the sampled level differs
// from the previous sample in the direction chosen by pos_sel.
module irq_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic pos_sel,
    output logic hit
);
    logic prev_q;

    // Hold the level seen at the previous clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    // Accept only the change direction picked by pos_sel.
    always_comb begin
        hit = (lvl != prev_q) && (lvl == pos_sel);
    end
endmodule

// File: rtl/irq_flag_reg.sv
// Module: interrupt flag register with per-bit set and clear vectors.
// A set and a clear of the same bit in one cycle leaves the bit set.
module irq_flag_reg #(
    parameter int WIDTH = irq_pkg::FLAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_vec,
    input  logic [WIDTH-1:0] clr_vec,
    output logic [WIDTH-1:0] flag_q
);
    // Clear first, then OR in the sets so no event is lost.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_vec) | set_vec;
    end
endmodule

// File: rtl/irq_en_reg.sv
// Module: interrupt enable register written in set/clear form.
// The top bit of the write data selects set (1) or clear (0) of the
// bits written as one; the rest are kept.
module irq_en_reg #(
    parameter int WIDTH  = irq_pkg::FLAG_W,
    parameter int DWIDTH = irq_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DWIDTH-1:0] wdata,
    output logic [WIDTH-1:0]  en_q
);
    localparam int SEL_BIT = DWIDTH - 1;

    // Apply set or clear of the written ones on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr) begin
            if (wdata[SEL_BIT]) en_q <= en_q | wdata[WIDTH-1:0];
            else                en_q <= en_q & ~wdata[WIDTH-1:0];
        end
    end
endmodule

// File: rtl/irq_flag_ctrl.sv
// Module: interrupt flag controller top.
// Collects control-line edges and strobe sources into a flag register,
// masks it with an enable register and drives irq. Holds the control
// register and the byte-wide read mux. Assumes all inputs are
// synchronous to clk and the control lines are low during reset.
module irq_flag_ctrl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_N-1:0] ctl_line,
    input  logic              tmr1_hit,
    input  logic              tmr2_hit,
    input  logic              shf_done,
    input  logic              tmr1_ack,
    input  logic              tmr2_ack,
    input  logic              shf_ack,
    input  logic              porta_ack,
    input  logic              portb_ack,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int PAD_W = DATA_W - CTRL_W;

    logic [CTRL_W-1:0] ctrl_q;
    logic [LINE_N-1:0] edge_hit;
    logic [FLAG_W-1:0] set_vec;
    logic [FLAG_W-1:0] clr_vec;
    logic [FLAG_W-1:0] flag_q;
    logic [FLAG_W-1:0] en_q;
    logic              wr_ctrl;
    logic              wr_flag;
    logic              wr_enab;

    // Decode register writes by address.
    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
        wr_flag = reg_wr && (reg_addr == RA_FLAG);
        wr_enab = reg_wr && (reg_addr == RA_ENAB);
    end

    // Control register: polarity selects and independent bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
    end

    // One edge detector per control line.
    for (genvar gi = 0; gi < LINE_N; gi++) begin : g_line
        irq_edge_det u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl     (ctl_line[gi]),
            .pos_sel (ctrl_q[gi]),
            .hit     (edge_hit[gi])
        );
    end

    // Gather set sources onto their flag bits.
    always_comb begin
        set_vec = '0;
        for (int i = 0; i < LINE_N; i++) begin
            set_vec[line_to_flag(i)] = edge_hit[i];
        end
        set_vec[FB_TMR1] = tmr1_hit;
        set_vec[FB_TMR2] = tmr2_hit;
        set_vec[FB_SHF]  = shf_done;
    end

    // Gather clear sources: write-one-to-clear and access strobes.
    always_comb begin
        clr_vec = wr_flag ? reg_wdata[FLAG_W-1:0] : '0;
        if (tmr1_ack) clr_vec[FB_TMR1] = 1'b1;
        if (tmr2_ack) clr_vec[FB_TMR2] = 1'b1;
        if (shf_ack)  clr_vec[FB_SHF]  = 1'b1;
        if (porta_ack) begin
            clr_vec[FB_A_PRI] = 1'b1;
            if (!ctrl_q[CB_A_IND]) clr_vec[FB_A_SEC] = 1'b1;
        end
        if (portb_ack) begin
            clr_vec[FB_B_PRI] = 1'b1;
            if (!ctrl_q[CB_B_IND]) clr_vec[FB_B_SEC] = 1'b1;
        end
    end

    irq_flag_reg #(.WIDTH(FLAG_W)) u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flag_q  (flag_q)
    );

    irq_en_reg #(.WIDTH(FLAG_W), .DWIDTH(DATA_W)) u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_enab),
        .wdata (reg_wdata),
        .en_q  (en_q)
    );

    // Request line: any flag that is also enabled.
    always_comb begin
        irq = |(flag_q & en_q);
    end

    // Read mux; flag bit 7 is the computed summary.
    always_comb begin
        unique case (reg_addr)
            RA_CTRL: reg_rdata = {{PAD_W{1'b0}}, ctrl_q};
            RA_FLAG: reg_rdata = {irq, flag_q};
            RA_ENAB: reg_rdata = {1'b1, en_q};
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
// Module: assertion checker for irq_flag_ctrl, attached by bind.
// Assumes control lines are low during reset and that no set source
// fires in the cycle of a write-one-to-clear checked by a_r4.
module irq_flag_ctrl_chk
    import irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [LINE_N-1:0] ctl_line,
    input logic              tmr1_hit,
    input logic              tmr2_hit,
    input logic              shf_done,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq,
    input logic [FLAG_W-1:0] flag_q,
    input logic [FLAG_W-1:0] en_q
);
    a_r1_no_irq_without_enabled_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & en_q) == '0) |-> !irq);

    a_r2_line_flag_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[FB_A_PRI]) |-> ($past(ctl_line[1]) != $past(ctl_line[1], 2)));

    a_r3_tmr1_sets: assert property (@(posedge clk) disable iff (!rst_n)
        tmr1_hit |=> flag_q[FB_TMR1]);

    a_r3_shf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        shf_done |=> flag_q[FB_SHF]);

    a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_FLAG && !tmr1_hit && !tmr2_hit && !shf_done
         && ctl_line == $past(ctl_line))
        |=> ((flag_q & $past(reg_wdata[FLAG_W-1:0])) == '0));

    a_r5_en_set: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_ENAB && reg_wdata[DATA_W-1])
        |=> ((en_q & $past(reg_wdata[FLAG_W-1:0])) == $past(reg_wdata[FLAG_W-1:0])));

    a_r5_en_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_ENAB && !reg_wdata[DATA_W-1])
        |=> ((en_q & $past(reg_wdata[FLAG_W-1:0])) == '0));

    a_r6_en_read_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == RA_ENAB) |-> reg_rdata[DATA_W-1]);

    a_r7_flag_read_summary: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == RA_FLAG) |-> (reg_rdata[DATA_W-1] == irq));

    a_r8_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (flag_q == '0 && en_q == '0));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_line  (ctl_line),
    .tmr1_hit  (tmr1_hit),
    .tmr2_hit  (tmr2_hit),
    .shf_done  (shf_done),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .flag_q    (flag_q),
    .en_q      (en_q)
);

// File: tb/irq_flag_ctrl_tb.sv
// Bench: sweeps edge/polarity combinations, all 128 flag patterns
// against several enable masks, and the clear/collision corner cases.
module irq_flag_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ctl_line = '0;
    logic [7:0] stb = '0;   // {portb,porta,shf_ack,tmr2_ack,tmr1_ack,shf_done,tmr2_hit,tmr1_hit}
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_flag_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_line  (ctl_line),
        .tmr1_hit  (stb[0]),
        .tmr2_hit  (stb[1]),
        .shf_done  (stb[2]),
        .tmr1_ack  (stb[3]),
        .tmr2_ack  (stb[4]),
        .shf_ack   (stb[5]),
        .porta_ack (stb[6]),
        .portb_ack (stb[7]),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [7:0] s);
        @(negedge clk);
        stb = s;
        @(negedge clk);
        stb = '0;
    endtask

    task automatic set_line(input logic [3:0] v);
        @(negedge clk);
        ctl_line = v;
        @(negedge clk);
    endtask

    // Sets all seven flags; leaves control = {ind, 4'hF}, lines low.
    task automatic set_all(input logic [1:0] ind);
        wr(2'd0, {2'b00, ind, 4'hF});
        set_line(4'hF);
        set_line(4'h0);
        pulse(8'h07);
    endtask

    task automatic do_reset();
        @(negedge clk);
        ctl_line = '0; stb = '0; reg_wr = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [6:0] emask [5];
        do_reset();

        // R8: reset state
        rd(2'd0, d); chk("R8 ctrl", d, 8'h00);
        rd(2'd1, d); chk("R8 flag", d, 8'h00);
        rd(2'd2, d); chk("R8 enab", d, 8'h80);
        chk("R8 irq", irq, 0);

        // R2: every line, polarity and direction
        for (int i = 0; i < 4; i++) begin
            for (int pol = 0; pol < 2; pol++) begin
                for (int dir = 0; dir < 2; dir++) begin
                    int lb;
                    lb = (i < 2) ? i : i + 1;
                    wr(2'd0, pol ? 8'(1 << i) : 8'h00);
                    if (dir == 0) set_line(4'(1 << i));
                    wr(2'd1, 8'h7F);
                    set_line(dir ? 4'(1 << i) : 4'h0);
                    rd(2'd1, d);
                    chk("R2 edge", d, (pol == dir) ? (1 << lb) : 0);
                    wr(2'd1, 8'h7F);
                    repeat (3) @(negedge clk);
                    rd(2'd1, d);
                    chk("R2 steady", d, 8'h00);
                    set_line(4'h0);
                    wr(2'd1, 8'h7F);
                end
            end
        end

        // R1 R4 R5 R6 R7: all flag patterns against several masks
        for (int v = 0; v < 128; v++) begin
            set_all(2'b00);
            wr(2'd1, 8'(7'h7F ^ 7'(v)));
            rd(2'd1, d);
            chk("R4 w1c", d[6:0], v);
            emask[0] = 7'h00; emask[1] = 7'h7F; emask[2] = 7'(v);
            emask[3] = 7'h7F ^ 7'(v); emask[4] = 7'(1 << (v % 7));
            for (int k = 0; k < 5; k++) begin
                wr(2'd2, 8'h7F);
                wr(2'd2, {1'b1, emask[k]});
                rd(2'd2, d);
                chk("R5 R6 enab", d, {1'b1, emask[k]});
                chk("R1 irq", irq, ((7'(v) & emask[k]) != 0) ? 1 : 0);
                rd(2'd1, d);
                chk("R7 summary", d[7], ((7'(v) & emask[k]) != 0) ? 1 : 0);
            end
        end

        // R5: partial clear and a set write of zeros
        wr(2'd2, 8'h80 | 8'h7F);
        wr(2'd2, 8'h05);
        rd(2'd2, d); chk("R5 clear", d, 8'hFA);
        wr(2'd2, 8'h80);
        rd(2'd2, d); chk("R5 set none", d, 8'hFA);
        wr(2'd2, 8'h7F);

        // R10: port access clears with and without independent bits
        set_all(2'b00); pulse(8'h40); rd(2'd1, d); chk("R10 A dep", d, 8'h7C);
        set_all(2'b01); pulse(8'h40); rd(2'd1, d); chk("R10 A ind", d, 8'h7D);
        set_all(2'b00); pulse(8'h80); rd(2'd1, d); chk("R10 B dep", d, 8'h67);
        set_all(2'b10); pulse(8'h80); rd(2'd1, d); chk("R10 B ind", d, 8'h6F);

        // R11: single-bit clear strobes
        set_all(2'b00); pulse(8'h08); rd(2'd1, d); chk("R11 tmr1", d, 8'h3F);
        set_all(2'b00); pulse(8'h10); rd(2'd1, d); chk("R11 tmr2", d, 8'h5F);
        set_all(2'b00); pulse(8'h20); rd(2'd1, d); chk("R11 shf", d, 8'h7B);

        // R3: strobe sources set again after a clear
        wr(2'd1, 8'h7F);
        pulse(8'h04); rd(2'd1, d); chk("R3 shf set", d, 8'h04);
        pulse(8'h20); rd(2'd1, d); chk("R3 shf clr", d, 8'h00);
        pulse(8'h04); rd(2'd1, d); chk("R3 shf again", d, 8'h04);
        pulse(8'h03); rd(2'd1, d); chk("R3 timers", d, 8'h64);
        wr(2'd1, 8'h7F);

        // R9: set beats clear in the same cycle
        pulse(8'h09); rd(2'd1, d); chk("R9 tmr1", d, 8'h40);
        pulse(8'h24); rd(2'd1, d); chk("R9 shf", d, 8'h44);
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h7F);
        @(negedge clk);
        ctl_line = 4'h1; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h01;
        @(negedge clk);
        reg_wr = 1'b0;
        rd(2'd1, d); chk("R9 edge vs w1c", d, 8'h01);
        set_line(4'h0);

        // R12: control layout, unused address
        wr(2'd0, 8'hFF);
        rd(2'd0, d); chk("R12 ctrl", d, 8'h3F);
        wr(2'd2, 8'h83);
        wr(2'd3, 8'hFF);
        rd(2'd3, d); chk("R12 addr3", d, 8'h00);
        rd(2'd0, d); chk("R12 ctrl kept", d, 8'h3F);
        rd(2'd2, d); chk("R12 enab kept", d, 8'h83);
        rd(2'd1, d); chk("R12 flag kept", d, 8'h81);

        // R8: reset in mid-run
        do_reset();
        rd(2'd0, d); chk("R8 ctrl again", d, 8'h00);
        rd(2'd1, d); chk("R8 flag again", d, 8'h00);
        rd(2'd2, d); chk("R8 enab again", d, 8'h80);
        chk("R8 irq again", irq, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule